// File: doc/BRIEF.md
# Parity Error Sample Concealment

This block sits on the audio output path of a digital audio receiver, after the demodulator and parity checker. Each received frame arrives with a one-cycle strobe, a sample word, a parity error flag, a lock error flag, decoded channel status bits and a two-bit sampling rate code. The block registers one output frame per strobe and hides bad samples from downstream logic.

It counts consecutive parity error frames. A short run of errors is covered by repeating the last good sample. A long run mutes the output to zero. The channel status and rate code are frozen for the whole parity error run. A lock error takes priority over everything else in the frame. It mutes the audio, clears the channel status to zero and forces the rate code to its cleared value.

Top module: `parity_conceal`

## Requirements
- R1: After reset, `sample_out` and `cs_out` are zero, `fs_out` is 2'b10 (the cleared code) and `out_vld` is low.
- R2: A frame with no parity error and no lock error puts its own sample, channel status and rate code on the outputs in the cycle after the strobe. `out_vld` is high for exactly that one cycle.
- R3: For the 1st through the REPEAT_LIMIT-th (default 8) consecutive parity error frames, `sample_out` repeats the last good sample.
- R4: From the (REPEAT_LIMIT+1)-th consecutive parity error frame onward, `sample_out` is all zeros.
- R5: During a parity error run of any length, `cs_out` and `fs_out` keep the values they held before the run.
- R6: A frame with a lock error gives `sample_out` = 0, `cs_out` = 0 and `fs_out` = 2'b10. This holds whether or not the parity error flag is also set.
- R7: The first good frame ends a run, and the run count returns to zero. Even after a muted run, this frame outputs its own sample at once.
- R8: The held last good sample changes only on good frames. A lock error clears it to zero, so parity errors that follow a lock error output zeros.
- R9: Between strobes, `sample_out`, `cs_out` and `fs_out` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe marking a received frame |
| sample_in | input | SAMPLE_W | Received audio sample |
| parity_err | input | 1 | Parity check failed for this frame |
| lock_err | input | 1 | PLL not locked for this frame |
| cs_in | input | CS_W | Decoded channel status bits |
| fs_in | input | 2 | Sampling rate code |
| sample_out | output | SAMPLE_W | Concealed audio sample |
| cs_out | output | CS_W | Held channel status |
| fs_out | output | 2 | Held rate code, 2'b10 when cleared |
| out_vld | output | 1 | Output frame valid pulse |

## Verification
The bench uses two kinds of directed runs. Parity runs of exactly 8 and of 9 or more frames separate the repeat case from the mute case at the limit. Recovery frames after a muted run show that the counter restarts.

Lock errors are tested in two ways: with the parity flag also raised, to show that lock handling wins, and followed by parity errors, to show that the held sample was cleared. Bursty random traffic with idle gaps checks the mix of runs against a frame-level model, and also checks that the outputs are stable between strobes.

// File: rtl/parity_conceal_pkg.sv
package parity_conceal_pkg;
  localparam logic [1:0] FS_CLEARED = 2'b10;

  typedef enum logic [1:0] {
    FR_GOOD   = 2'b00,
    FR_PARITY = 2'b01,
    FR_LOCK   = 2'b10
  } frame_kind_e;

  function automatic frame_kind_e classify(input logic perr, input logic lerr);
    if (lerr)      return FR_LOCK;
    else if (perr) return FR_PARITY;
    else           return FR_GOOD;
  endfunction
endpackage

// File: rtl/err_run_ctr.sv
module err_run_ctr
  import parity_conceal_pkg::*;
#(
  parameter int REPEAT_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_en,
  input  frame_kind_e kind,
  output logic        over_limit
);
  localparam int CNT_W = $clog2(REPEAT_LIMIT + 2);
  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(REPEAT_LIMIT + 1);

  logic [CNT_W-1:0] run_q, run_d, run_inc;

  always_comb begin
    run_inc = (run_q == SAT_VAL) ? SAT_VAL : run_q + CNT_W'(1);
    run_d   = run_q;
    if (frame_en) begin
      unique case (kind)
        FR_PARITY: run_d = run_inc;
        default:   run_d = '0;
      endcase
    end
  end

  assign over_limit = (run_inc > CNT_W'(REPEAT_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (frame_en) run_q <= run_d;
  end

  assert_run_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= SAT_VAL);
  assert_run_clear_on_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && kind == FR_GOOD) |=> run_q == '0);
endmodule

// File: rtl/sample_hold.sv
module sample_hold
  import parity_conceal_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_en,
  input  frame_kind_e         kind,
  input  logic                over_limit,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic [SAMPLE_W-1:0] sample_out
);
  logic [SAMPLE_W-1:0] last_q, last_d, out_q, out_d;

  always_comb begin
    last_d = last_q;
    out_d  = out_q;
    if (frame_en) begin
      unique case (kind)
        FR_GOOD: begin
          last_d = sample_in;
          out_d  = sample_in;
        end
        FR_PARITY: out_d = over_limit ? '0 : last_q;
        default: begin
          last_d = '0;
          out_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      out_q  <= '0;
    end else if (frame_en) begin
      last_q <= last_d;
      out_q  <= out_d;
    end
  end

  assign sample_out = out_q;

  assert_last_only_good_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && kind == FR_PARITY) |=> $stable(last_q));
  assert_repeat_under_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && kind == FR_PARITY && !over_limit) |=> out_q == $past(last_q));
endmodule

// File: rtl/cs_hold.sv
module cs_hold
  import parity_conceal_pkg::*;
#(
  parameter int CS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_en,
  input  frame_kind_e     kind,
  input  logic [CS_W-1:0] cs_in,
  input  logic [1:0]      fs_in,
  output logic [CS_W-1:0] cs_out,
  output logic [1:0]      fs_out
);
  logic [CS_W-1:0] cs_q, cs_d;
  logic [1:0]      fs_q, fs_d;

  always_comb begin
    cs_d = cs_q;
    fs_d = fs_q;
    if (frame_en) begin
      unique case (kind)
        FR_GOOD: begin
          cs_d = cs_in;
          fs_d = fs_in;
        end
        FR_LOCK: begin
          cs_d = '0;
          fs_d = FS_CLEARED;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0;
      fs_q <= FS_CLEARED;
    end else if (frame_en) begin
      cs_q <= cs_d;
      fs_q <= fs_d;
    end
  end

  assign cs_out = cs_q;
  assign fs_out = fs_q;
endmodule

// File: rtl/parity_conceal.sv
module parity_conceal
  import parity_conceal_pkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int CS_W         = 16,
  parameter int REPEAT_LIMIT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_vld,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                parity_err,
  input  logic                lock_err,
  input  logic [CS_W-1:0]     cs_in,
  input  logic [1:0]          fs_in,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic [CS_W-1:0]     cs_out,
  output logic [1:0]          fs_out,
  output logic                out_vld
);
  frame_kind_e kind;
  logic        over_limit;
  logic        vld_q;

  assign kind = classify(parity_err, lock_err);

  err_run_ctr #(.REPEAT_LIMIT(REPEAT_LIMIT)) u_run (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_vld), .kind(kind),
    .over_limit(over_limit)
  );

  sample_hold #(.SAMPLE_W(SAMPLE_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_vld), .kind(kind),
    .over_limit(over_limit), .sample_in(sample_in), .sample_out(sample_out)
  );

  cs_hold #(.CS_W(CS_W)) u_cs (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_vld), .kind(kind),
    .cs_in(cs_in), .fs_in(fs_in), .cs_out(cs_out), .fs_out(fs_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= frame_vld;
  end
  assign out_vld = vld_q;

  assert_lock_mutes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && lock_err) |=> (sample_out == '0 && cs_out == '0 && fs_out == FS_CLEARED));
  assert_cs_held_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && parity_err && !lock_err) |=> ($stable(cs_out) && $stable(fs_out)));
  assert_good_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !parity_err && !lock_err) |=> sample_out == $past(sample_in));
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> ($stable(sample_out) && $stable(cs_out) && $stable(fs_out)));
endmodule

// File: tb/parity_conceal_bench.sv
`timescale 1ns/1ps
module parity_conceal_bench;
  localparam int SW = 24, CW = 16, LIM = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_vld = 1'b0, parity_err = 1'b0, lock_err = 1'b0;
  logic [SW-1:0] sample_in = '0;
  logic [CW-1:0] cs_in = '0;
  logic [1:0]    fs_in = '0;
  logic [SW-1:0] sample_out;
  logic [CW-1:0] cs_out;
  logic [1:0]    fs_out;
  logic          out_vld;

  int checks = 0, fails = 0;
  bit done = 0;

  int unsigned   m_run;
  logic [SW-1:0] m_last, m_samp;
  logic [CW-1:0] m_cs;
  logic [1:0]    m_fs;

  always #2.5 clk = ~clk;

  parity_conceal #(.SAMPLE_W(SW), .CS_W(CW), .REPEAT_LIMIT(LIM)) u_parity_conceal (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .sample_in(sample_in),
    .parity_err(parity_err), .lock_err(lock_err), .cs_in(cs_in), .fs_in(fs_in),
    .sample_out(sample_out), .cs_out(cs_out), .fs_out(fs_out), .out_vld(out_vld)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_for(input logic p, input logic l);
    if (l) return "R6";
    if (!p) return "R2/R7";
    if (m_run > LIM) return "R4";
    return "R3/R8";
  endfunction

  task automatic model(input logic [SW-1:0] s, input logic p, input logic l,
                       input logic [CW-1:0] c, input logic [1:0] f);
    if (l) begin
      m_run = 0; m_last = '0; m_samp = '0; m_cs = '0; m_fs = 2'b10;
    end else if (p) begin
      if (m_run <= LIM) m_run++;
      m_samp = (m_run > LIM) ? '0 : m_last;
    end else begin
      m_run = 0; m_last = s; m_samp = s; m_cs = c; m_fs = f;
    end
  endtask

  task automatic frame(input logic [SW-1:0] s, input logic p, input logic l,
                       input logic [CW-1:0] c, input logic [1:0] f);
    string t;
    frame_vld = 1'b1; sample_in = s; parity_err = p; lock_err = l; cs_in = c; fs_in = f;
    model(s, p, l, c, f);
    t = tag_for(p, l);
    @(negedge clk);
    frame_vld = 1'b0;
    chk({t, " sample"}, 64'(sample_out), 64'(m_samp));
    chk(p && !l ? "R5 cs" : {t, " cs"}, 64'(cs_out), 64'(m_cs));
    chk(p && !l ? "R5 fs" : {t, " fs"}, 64'(fs_out), 64'(m_fs));
    chk("R2 out_vld", 64'(out_vld), 64'd1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      sample_in = SW'($urandom); cs_in = CW'($urandom); parity_err = 1'($urandom); lock_err = 1'($urandom);
      @(negedge clk);
      chk("R9 sample", 64'(sample_out), 64'(m_samp));
      chk("R9 cs", 64'(cs_out), 64'(m_cs));
      chk("R2 out_vld low", 64'(out_vld), 64'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7319));
    m_run = 0; m_last = '0; m_samp = '0; m_cs = '0; m_fs = 2'b10;
    repeat (3) @(negedge clk);
    chk("R1 sample", 64'(sample_out), 64'd0);
    chk("R1 cs", 64'(cs_out), 64'd0);
    chk("R1 fs", 64'(fs_out), 64'd2);
    chk("R1 vld", 64'(out_vld), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 good frames, R3 exactly LIM errors repeat
    frame(24'h123456, 0, 0, 16'hBEEF, 2'b01);
    idle(2);
    for (int i = 0; i < LIM; i++) frame(SW'($urandom), 1, 0, CW'($urandom), 2'b11);
    // R7 recovery resets the run
    frame(24'h0000AA, 0, 0, 16'h1111, 2'b00);
    for (int i = 0; i < LIM; i++) frame(SW'($urandom), 1, 0, 16'h0, 2'b11);
    // R4 9th and later errors mute
    for (int i = 0; i < 4; i++) frame(SW'($urandom), 1, 0, 16'h0, 2'b11);
    // R7 first good after mute
    frame(24'hABCDEF, 0, 0, 16'h2222, 2'b01);
    chk("R7 own sample after mute", 64'(sample_out), 64'h0000_0000_00AB_CDEF);
    // R6 lock with parity also set
    frame(24'h777777, 1, 1, 16'hFFFF, 2'b00);
    // R8 errors after lock repeat the cleared value
    frame(24'h555555, 1, 0, 16'hFFFF, 2'b00);
    chk("R8 zero after lock", 64'(sample_out), 64'd0);
    frame(24'h010203, 0, 0, 16'h3333, 2'b11);

    // random bursty traffic
    for (int n = 0; n < 600; n++) begin
      logic p, l;
      int unsigned r = $urandom_range(0, 99);
      l = (r < 4);
      p = (m_run > 0) ? (r < 85) : (r < 25);
      frame(SW'($urandom), p, l, CW'($urandom), 2'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule